// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address presented to a synchronous burst memory during a four-beat burst. When a begin-burst strobe is accepted, it captures a full starting address from an external bus. The low address bits then step through a four-entry sequence on each clock edge where the active-low advance input is driven low. The sequence is either a plain modulo increment or an interleaved pattern, in which the low bits equal the starting value XOR a beat count.

Deasserting advance suspends the burst, and the current address is held. A later advance resumes the burst from the point where it stopped. The upper address bits are captured with the starting address and pass through untouched for the whole burst. The output is registered, so a new address appears on the clock edge that accepts the load or advance.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset, sampled high on a clock edge, drives the whole output address to zero after that edge.
- R2: A clock edge with `load_i` high makes `addr_o` equal to the `addr_i` value sampled at that edge.
- R3: Load takes priority over advance: an edge with `load_i` high and `adv_n_i` low still yields the loaded address and restarts the beat count.
- R4: With `order_i` low at load (linear order), each advance adds one, modulo 4, to the two low bits of `addr_o`. For example, start 01 gives 01, 10, 11, 00.
- R5: With `order_i` high at load (interleaved order), the low bits equal the start XOR the beat count. Start 01 gives 01, 00, 11, 10. Start 10 gives 10, 11, 00, 01. Start 11 gives 11, 10, 01, 00.
- R6: The fourth advance after a load returns the low bits to the loaded starting value, in both orders.
- R7: An edge with `load_i` low and `adv_n_i` high holds `addr_o` unchanged. A later advance continues from the held position.
- R8: The upper address bits (above the two low bits) change only on load. Advancing, holding, and changing `addr_i` without a load leave them unchanged.
- R9: The ordering is captured with the load. Changing `order_i` in the middle of a burst does not alter the sequence produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Begin-burst strobe; captures `addr_i` |
| adv_n_i | input | 1 | Advance to the next beat, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | Starting address for a new burst |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with a 12-bit address and the default two-bit beat field. This gives ten upper bits, enough to confirm that patterns on the upper bits survive advancing, holding and bus changes without a load.

With the beat field at its default of two, every starting value and the wrap on the fourth advance can be reached within a few cycles. All three interleaved tables are compared against literal values. Suspensions, mid-burst reloads with advance asserted, and changes to the order input mid-burst are mixed into the same runs.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_beat_step.sv
// Next value of the beat counter: clear on load, step on advance, else hold.
module burst_beat_step #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] beat_q,
    input  logic              load,
    input  logic              adv_n,
    output logic [BEAT_W-1:0] beat_d
);
    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    always_comb begin
        beat_d = beat_q;
        if (load) begin
            beat_d = '0;
        end else if (!adv_n) begin
            beat_d = beat_q + ONE;
        end
    end
endmodule

// File: rtl/burst_order_map.sv
// Maps a start value and beat count to the low address bits.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  burst_order_e      order,
    output logic [BEAT_W-1:0] low
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    assign lin_low = start + beat;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_low[b] = start[b] ^ beat[b];
    end

    always_comb begin
        unique case (order)
            ORD_INTERLEAVE: low = ilv_low;
            default:        low = lin_low;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              adv_n_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int UP_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UP_W-1:0]   upper;
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
        burst_order_e      order;
        logic [ADDR_W-1:0] addr;
    } state_t;

    state_t st_d, st_q;

    logic [UP_W-1:0]   upper_nx;
    logic [BEAT_W-1:0] start_nx;
    burst_order_e      order_nx;
    logic [BEAT_W-1:0] beat_nx;
    logic [BEAT_W-1:0] low_nx;

    // Capture of burst parameters on load
    always_comb begin
        upper_nx = st_q.upper;
        start_nx = st_q.start;
        order_nx = st_q.order;
        if (load_i) begin
            upper_nx = addr_i[ADDR_W-1:BEAT_W];
            start_nx = addr_i[BEAT_W-1:0];
            order_nx = burst_order_e'(order_i);
        end
    end

    burst_beat_step #(.BEAT_W(BEAT_W)) u_step (
        .beat_q (st_q.beat),
        .load   (load_i),
        .adv_n  (adv_n_i),
        .beat_d (beat_nx)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .start (start_nx),
        .beat  (beat_nx),
        .order (order_nx),
        .low   (low_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.upper = upper_nx;
        st_d.start = start_nx;
        st_d.order = order_nx;
        st_d.beat  = beat_nx;
        st_d.addr  = {upper_nx, low_nx};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic              adv_n_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              order_q
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> addr_o == '0);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> addr_o == $past(addr_i));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && adv_n_i) |=> $stable(addr_o));

    // R8
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !adv_n_i && !order_q) |=>
            addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + BEAT_W'(1));

    // R5
    ilv_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !adv_n_i && order_q) |=>
            $countones(addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) > 0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .adv_n_i (adv_n_i),
    .addr_i  (addr_i),
    .addr_o  (addr_o),
    .order_q (st_q.order)
);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_i = 1'b0;
    logic          adv_n_i = 1'b1;
    logic          order_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u_burst_addr_gen (
        .clk(clk), .rst(rst), .load_i(load_i), .adv_n_i(adv_n_i),
        .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o)
    );

    typedef struct {
        logic [AW-1:0] exp;
        logic [AW-1:0] mask;
        string         tag;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int errors = 0;

    // reference model state
    logic [AW-3:0] m_up = '0;
    logic [1:0]    m_st = '0;
    logic [1:0]    m_cnt = '0;
    logic          m_ord = 1'b0;

    task automatic step(input logic l, input logic an, input logic o,
                        input logic [AW-1:0] a, input int lit, input string tag);
        item_t it;
        logic [1:0] lo;
        @(negedge clk);
        load_i = l; adv_n_i = an; order_i = o; addr_i = a;
        @(posedge clk);
        if (l) begin
            m_up = a[AW-1:2]; m_st = a[1:0]; m_cnt = 2'd0; m_ord = o;
        end else if (!an) begin
            m_cnt = m_cnt + 2'd1;
        end
        lo = m_ord ? (m_st ^ m_cnt) : (m_st + m_cnt);
        it.exp = {m_up, lo}; it.mask = '1; it.tag = tag;
        sb.push_back(it);
        if (lit >= 0) begin
            it.exp = AW'(lit); it.mask = AW'(3); it.tag = {tag, " table"};
            sb.push_back(it);
        end
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if ((addr_o & it.mask) !== (it.exp & it.mask)) begin
                errors++;
                $display("FAIL %s: addr_o=%h expected=%h (mask %h)",
                         it.tag, addr_o, it.exp, it.mask);
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (addr_o !== '0) begin
            errors++;
            $display("FAIL R1: addr_o=%h expected=%h", addr_o, {AW{1'b0}});
        end
        rst = 1'b0;

        // R2 R4 R6: linear from 01, wrap on fourth advance
        step(1, 1, 0, 12'h5A1, 1, "R2 load");
        step(0, 0, 0, 12'h000, 2, "R4 lin");
        step(0, 0, 0, 12'h000, 3, "R4 lin");
        step(0, 0, 0, 12'h000, 0, "R4 lin");
        step(0, 0, 0, 12'h000, 1, "R6 wrap lin");

        // R5 R6: interleaved tables
        step(1, 1, 1, 12'hA71, 1, "R5 ilv01");
        step(0, 0, 1, 12'h000, 0, "R5 ilv01");
        step(0, 0, 1, 12'h000, 3, "R5 ilv01");
        step(0, 0, 1, 12'h000, 2, "R5 ilv01");
        step(0, 0, 1, 12'h000, 1, "R6 wrap ilv");
        step(1, 1, 1, 12'h3C2, 2, "R5 ilv10");
        step(0, 0, 1, 12'h000, 3, "R5 ilv10");
        step(0, 0, 1, 12'h000, 0, "R5 ilv10");
        step(0, 0, 1, 12'h000, 1, "R5 ilv10");
        step(1, 1, 1, 12'hFFF, 3, "R5 ilv11");
        step(0, 0, 1, 12'h000, 2, "R5 ilv11");
        step(0, 0, 1, 12'h000, 1, "R5 ilv11");
        step(0, 0, 1, 12'h000, 0, "R5 ilv11");

        // R7: suspend and resume, R8: bus changes without load ignored
        step(1, 1, 0, 12'h812, 2, "R7 load");
        step(0, 0, 0, 12'h000, 3, "R7 adv");
        step(0, 1, 0, 12'hFFF, 3, "R7 R8 hold");
        step(0, 1, 1, 12'h555, 3, "R7 R8 hold");
        step(0, 1, 0, 12'hAAA, 3, "R7 hold");
        step(0, 0, 0, 12'h7F0, 0, "R7 resume");

        // R3: load wins over advance mid-burst
        step(1, 0, 1, 12'h6B3, 3, "R3 prio");
        step(0, 0, 1, 12'h000, 2, "R3 after");
        step(1, 0, 0, 12'h100, 0, "R3 prio lin");

        // R9: order input toggled mid-burst has no effect
        step(0, 0, 1, 12'hFFF, 1, "R9 toggle");
        step(0, 0, 1, 12'h000, 2, "R9 toggle");
        step(0, 0, 0, 12'h000, 3, "R9 toggle");
        step(1, 1, 1, 12'h2D1, 1, "R9 load ilv");
        step(0, 0, 0, 12'h000, 0, "R9 toggle ilv");
        step(0, 0, 0, 12'h000, 3, "R8 R9 ilv");

        // R1 again mid-burst
        step(0, 0, 1, 12'h000, 2, "R5 pre-reset");
        @(negedge clk);
        rst = 1'b1; adv_n_i = 1'b0;
        @(negedge clk);
        checks++;
        if (addr_o !== '0) begin
            errors++;
            $display("FAIL R1 mid: addr_o=%h expected=%h", addr_o, {AW{1'b0}});
        end
        rst = 1'b0; adv_n_i = 1'b1;
        m_up = '0; m_st = '0; m_cnt = '0; m_ord = 1'b0;
        step(0, 0, 0, 12'h000, 1, "R1 R4 post-reset");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule